// File: doc/BRIEF.md
# Three-State Watchdog Supervisor

This block supervises a processor through one watchdog line that can be driven high, driven low or left open. An analog front end outside the block turns the line into two logic signals: a synchronized level and a flag that is set while the line floats. While the line is driven, every change of level in either direction restarts a timeout measured in millisecond ticks. If the line stays at one level, high or low, for the whole timeout, the block drives its active-low watchdog output low and issues a one-cycle reset request. That request is meant to start an external reset stretcher.

A floating line turns supervision off. The counter is held at zero and the watchdog output stays high. After a timeout, the watchdog output stays low until the processor changes the level again. That change also starts a new timeout period.

Top module: `tristate_wdog`

## Requirements
- R1: After reset is released, `wdo_n` is 1 and `rst_req` is 0.
- R2: With the line held low and not floating, `wdo_n` stays 1 through TIMEOUT_MS-1 ticks after the last level change. It goes to 0 in the clock cycle after the TIMEOUT_MS-th tick.
- R3: With the line held high, the same timing as R2 applies.
- R4: Each timeout gives exactly one `rst_req` pulse, one clock cycle wide, in the same cycle that `wdo_n` falls. While the line stays stuck, there is no further pulse.
- R5: A level change of `wd_level` in either direction, seen by comparing it with its value on the previous clock, restarts the tick count from zero.
- R6: While `wd_float` is 1, ticks and level changes have no effect: `wdo_n` stays 1, no `rst_req` is issued, and the count is held at zero. After `wd_float` returns to 0, a full TIMEOUT_MS ticks are needed for a timeout.
- R7: After a timeout, `wdo_n` stays 0 until the next level change. That change sets `wdo_n` to 1 one cycle later and starts a fresh timeout period.
- R8: If `wd_float` is set while `wdo_n` is 0, `wdo_n` returns to 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| wd_level | input | 1 | Synchronized watchdog line level |
| wd_float | input | 1 | 1 while the watchdog line floats |
| wdo_n | output | 1 | Watchdog output, low after a timeout |
| rst_req | output | 1 | One-cycle reset request at each timeout |

## Verification
The checker tests on every cycle the properties that need no long history. The reset request is never wider than one cycle. It appears exactly when the watchdog output falls. A floating line forces the output high and blocks any request. A stuck, driven line cannot bring the output back high. Only the bench scenarios can show the timing that needs the tick count: no timeout after one tick short, a timeout on the exact tick, restart by edges in both directions, and the full period that follows release from float.

// File: rtl/tristate_wdog.sv
module tristate_wdog #(
  parameter int TIMEOUT_MS = 1600,
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic wd_level,
  input  logic wd_float,
  output logic wdo_n,
  output logic rst_req
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_MS - 1);

  logic             lvl_q;
  logic             expired;
  logic [CNT_W-1:0] cnt;
  logic             flip;
  logic             hit;

  assign flip  = wd_level ^ lvl_q;
  assign hit   = tick_1ms && !expired && (cnt == LAST);
  assign wdo_n = ~expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      expired <= 1'b0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      lvl_q   <= wd_level;
      rst_req <= 1'b0;
      if (wd_float || flip) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (hit) begin
        cnt     <= '0;
        expired <= 1'b1;
        rst_req <= 1'b1;
      end else if (tick_1ms && !expired) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tristate_wdog_chk.sv
module tristate_wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_level,
  input logic wd_float,
  input logic wdo_n,
  input logic rst_req
);

  assert_req_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_with_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !wdo_n);

  assert_fall_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n) |-> rst_req);

  assert_float_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float |=> (wdo_n && !rst_req));

  assert_stuck_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !wd_float && wd_level == $past(wd_level)) |=> !wdo_n);

endmodule

bind tristate_wdog tristate_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_level(wd_level), .wd_float(wd_float),
  .wdo_n(wdo_n), .rst_req(rst_req)
);

// File: tb/tristate_wdog_test.sv
`timescale 1ns/1ps
module tristate_wdog_test;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0;
  logic wd_level = 1'b0;
  logic wd_float = 1'b0;
  logic wdo_n, rst_req;
  int total = 0, bad = 0, pulses = 0;

  always #4 clk = ~clk;

  tristate_wdog #(.TIMEOUT_MS(T)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .wd_level(wd_level),
    .wd_float(wd_float), .wdo_n(wdo_n), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_n && rst_req) pulses <= pulses + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic set_level(input logic v);
    @(negedge clk) wd_level = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 wdo_n", wdo_n, 1);
    check("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_stuck(input logic v, input string req);
    int p0;
    set_level(~v);
    set_level(v);
    p0 = pulses;
    ticks(T - 1);
    check({req, " high before timeout"}, wdo_n, 1);
    ticks(1);
    check({req, " low at timeout"}, wdo_n, 0);
    check("R4 request present", rst_req, 1);
    @(negedge clk);
    check("R4 request one cycle", rst_req, 0);
    ticks(2 * T);
    check("R7 stays low while stuck", wdo_n, 0);
    check("R4 single pulse", pulses - p0, 1);
  endtask

  task automatic t_recover;
    set_level(~wd_level);
    check("R7 edge raises wdo_n", wdo_n, 1);
    ticks(T - 1);
    check("R7 fresh period", wdo_n, 1);
    ticks(1);
    check("R7 times out again", wdo_n, 0);
  endtask

  task automatic t_restart;
    set_level(~wd_level);
    ticks(T - 1);
    set_level(1'b1);
    ticks(T - 1);
    check("R5 rising edge restarts", wdo_n, 1);
    set_level(1'b0);
    ticks(T - 1);
    check("R5 falling edge restarts", wdo_n, 1);
    ticks(1);
    check("R5 full period after edge", wdo_n, 0);
  endtask

  task automatic t_float;
    int p0;
    check("R8 precondition low", wdo_n, 0);
    @(negedge clk) wd_float = 1'b1;
    @(negedge clk);
    check("R8 float raises wdo_n", wdo_n, 1);
    p0 = pulses;
    ticks(T + 3);
    set_level(1'b1);
    ticks(2 * T);
    check("R6 wdo_n high while floating", wdo_n, 1);
    check("R6 no request while floating", pulses - p0, 0);
    @(negedge clk) wd_float = 1'b0;
    ticks(T - 1);
    check("R6 count held at zero", wdo_n, 1);
    ticks(1);
    check("R6 full period after release", wdo_n, 0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stuck(1'b0, "R2");
    t_recover();
    t_stuck(1'b1, "R3");
    t_restart();
    t_float();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule